// File: doc/BRIEF.md
# Delay-Line Phase Programming Sequencer

This block moves a clock-recovery delay line to a new sampling phase. It does this through a sequence of read-modify-write updates to a 32-bit delay-line configuration register. A single strobe starts the sequence, which carries a 4-bit phase request. The sequencer first quiesces the recovered clock output, with clock recovery handed over to external phase selection. It then waits for the register's readback to show the clock output off. Next it writes the phase as a Gray code and turns the clock output back on. It waits for the readback to confirm the output is on. Finally it returns clock recovery to internal selection.

Each wait is a poll. The poll samples the clock-output-enable readback and gives up after a bounded number of microsecond ticks. The ticks come from a clock-cycle divider. A successful sequence ends with a one-cycle done pulse. A poll that times out abandons the sequence with a one-cycle error pulse and reports the phase that failed. The surrounding logic supplies the register's current value on a read port. It takes each write as a full 32-bit word.

Top module: `dll_phase_seq`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `cfg_wr_en`, `done` and `err` are all low.
- R2: In the cycle after a `start` is accepted in idle, one write occurs. The word is the current readback with bit 17 (recovery enable) and bit 18 (clock-output enable) cleared, and bit 16 (delay-line enable) and bit 19 (external selection) set. All other bits are unchanged.
- R3: After the first write, no further write occurs until readback bit 18 is 0. Readback is sampled every cycle.
- R4: The next write puts the Gray code of the requested phase (code = p XOR (p >> 1), for example 5 gives 7 and 15 gives 8) into bits 23:20. All other bits are unchanged.
- R5: In the cycle right after the phase write, a write sets bit 18 and changes nothing else.
- R6: No further write occurs until readback bit 18 is 1.
- R7: The last write sets bit 17 and clears bit 19 and changes nothing else. Together with R2, bits 31:24 and 15:0 of the register are never altered.
- R8: Each poll restarts a tick divider on entry. A tick falls every TICK_DIV cycles. The poll fails at the POLL_LIMIT-th tick without a match, which is poll cycle POLL_LIMIT*TICK_DIV-1 counted from 0. A match seen in that same cycle still succeeds.
- R9: On a poll failure, `err` pulses for one cycle in the next cycle. `fail_phase` shows the requested phase from that cycle on. No further write follows, and the block is idle again.
- R10: `done` pulses for one cycle, in the cycle after the last write. `busy` is low in that cycle.
- R11: A `start` while `busy` is high is ignored. The running sequence keeps its phase and its timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| phase_req | input | PHASE_W | Requested phase, binary |
| cfg_rd | input | REG_W | Current configuration register value, including the clock-output-enable readback |
| cfg_wr_en | output | 1 | Write strobe for the configuration register |
| cfg_wr_data | output | REG_W | Full word to write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on poll timeout |
| fail_phase | output | PHASE_W | Phase of the most recent failed sequence |

## Verification
A wrong step state shows up at the ports at once: a write strobe appears or goes missing in the very cycle it should not, or a word carries bits out of order. A wrong tick or attempt count moves the end of a poll. That shows as a write or an error pulse one or more cycles early or late, which a per-cycle comparison catches at the first mismatch. A wrong latched phase stays hidden until the phase write or the error report, and shows up in bits 23:20 or in `fail_phase`. The boundary delays, where the match arrives exactly at the last tick or one cycle after it, separate an off-by-one in the limit from correct behaviour.

// File: rtl/dps_pkg.sv
package dps_pkg;

   typedef enum logic [2:0] {
      S_IDLE     = 3'd0,
      S_QUIESCE  = 3'd1,
      S_WAIT_OFF = 3'd2,
      S_PHASE    = 3'd3,
      S_ENABLE   = 3'd4,
      S_WAIT_ON  = 3'd5,
      S_LOCKIN   = 3'd6
   } seq_state_t;

endpackage

// File: rtl/dps_gray_enc.sv
module dps_gray_enc #(
   parameter int W = 4
) (
   input  logic [W-1:0] bin,
   output logic [W-1:0] code
);

   if (W < 1) begin : g_bad_w
      $error("dps_gray_enc: W must be at least 1");
   end

   assign code[W-1] = bin[W-1];

   for (genvar i = 0; i < W - 1; i++) begin : g_bit
      assign code[i] = bin[i] ^ bin[i+1];
   end

endmodule

// File: rtl/dps_us_tick.sv
module dps_us_tick #(
   parameter int DIV = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);

   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("dps_us_tick: DIV must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt <= '0;
      end else if (cnt == LAST) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign tick = en && (cnt == LAST);

endmodule

// File: rtl/dps_poll_limit.sv
module dps_poll_limit #(
   parameter int LIMIT = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic expired
);

   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("dps_poll_limit: LIMIT must be at least 2");
   end

   logic [CW-1:0] seen;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         seen <= '0;
      end else if (tick && (seen != LAST)) begin
         seen <= seen + 1'b1;
      end
   end

   assign expired = tick && (seen == LAST);

endmodule

// File: rtl/dps_cfg_rmw.sv
module dps_cfg_rmw
   import dps_pkg::*;
#(
   parameter int REG_W       = 32,
   parameter int PHASE_W     = 4,
   parameter int SEL_LSB     = 20,
   parameter int DLL_EN_BIT  = 16,
   parameter int CDR_EN_BIT  = 17,
   parameter int CKOUT_BIT   = 18,
   parameter int CDR_EXT_BIT = 19
) (
   input  seq_state_t         step,
   input  logic [REG_W-1:0]   rd,
   input  logic [PHASE_W-1:0] sel_code,
   output logic [REG_W-1:0]   wr
);

   always_comb begin
      wr = rd;
      unique case (step)
         S_QUIESCE: begin
            wr[CDR_EN_BIT]  = 1'b0;
            wr[CKOUT_BIT]   = 1'b0;
            wr[CDR_EXT_BIT] = 1'b1;
            wr[DLL_EN_BIT]  = 1'b1;
         end
         S_PHASE: begin
            wr[SEL_LSB +: PHASE_W] = sel_code;
         end
         S_ENABLE: begin
            wr[CKOUT_BIT] = 1'b1;
         end
         S_LOCKIN: begin
            wr[CDR_EN_BIT]  = 1'b1;
            wr[CDR_EXT_BIT] = 1'b0;
         end
         default: begin
            wr = rd;
         end
      endcase
   end

endmodule

// File: rtl/dll_phase_seq.sv
module dll_phase_seq
   import dps_pkg::*;
#(
   parameter int REG_W       = 32,
   parameter int PHASE_W     = 4,
   parameter int SEL_LSB     = 20,
   parameter int DLL_EN_BIT  = 16,
   parameter int CDR_EN_BIT  = 17,
   parameter int CKOUT_BIT   = 18,
   parameter int CDR_EXT_BIT = 19,
   parameter int TICK_DIV    = 250,
   parameter int POLL_LIMIT  = 50
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [PHASE_W-1:0] phase_req,
   input  logic [REG_W-1:0]   cfg_rd,
   output logic               cfg_wr_en,
   output logic [REG_W-1:0]   cfg_wr_data,
   output logic               busy,
   output logic               done,
   output logic               err,
   output logic [PHASE_W-1:0] fail_phase
);

   localparam int SEL_MSB = SEL_LSB + PHASE_W - 1;

   if (SEL_MSB >= REG_W) begin : g_bad_sel
      $error("dll_phase_seq: phase field exceeds register width");
   end
   if ((DLL_EN_BIT >= REG_W) || (CDR_EN_BIT >= REG_W) ||
       (CKOUT_BIT >= REG_W) || (CDR_EXT_BIT >= REG_W)) begin : g_bad_bit
      $error("dll_phase_seq: control bit outside register");
   end
   if ((CKOUT_BIT >= SEL_LSB) && (CKOUT_BIT <= SEL_MSB)) begin : g_overlap
      $error("dll_phase_seq: clock-output bit overlaps phase field");
   end
   if ((TICK_DIV < 2) || (POLL_LIMIT < 2)) begin : g_bad_timing
      $error("dll_phase_seq: TICK_DIV and POLL_LIMIT must be at least 2");
   end

   seq_state_t         state, state_n;
   logic [PHASE_W-1:0] phase_q;
   logic [PHASE_W-1:0] gray_code;
   logic               polling;
   logic               tick;
   logic               expired;
   logic               ckout_seen;
   logic               fin_ok, fin_bad;

   assign polling    = (state == S_WAIT_OFF) || (state == S_WAIT_ON);
   assign ckout_seen = cfg_rd[CKOUT_BIT];

   dps_gray_enc #(.W(PHASE_W)) u_gray (
      .bin  (phase_q),
      .code (gray_code)
   );

   dps_us_tick #(.DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (polling),
      .tick  (tick)
   );

   dps_poll_limit #(.LIMIT(POLL_LIMIT)) u_limit (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (!polling),
      .tick    (tick),
      .expired (expired)
   );

   dps_cfg_rmw #(
      .REG_W       (REG_W),
      .PHASE_W     (PHASE_W),
      .SEL_LSB     (SEL_LSB),
      .DLL_EN_BIT  (DLL_EN_BIT),
      .CDR_EN_BIT  (CDR_EN_BIT),
      .CKOUT_BIT   (CKOUT_BIT),
      .CDR_EXT_BIT (CDR_EXT_BIT)
   ) u_rmw (
      .step     (state),
      .rd       (cfg_rd),
      .sel_code (gray_code),
      .wr       (cfg_wr_data)
   );

   always_comb begin
      state_n = state;
      fin_ok  = 1'b0;
      fin_bad = 1'b0;
      unique case (state)
         S_IDLE:     if (start) state_n = S_QUIESCE;
         S_QUIESCE:  state_n = S_WAIT_OFF;
         S_WAIT_OFF: begin
            if (!ckout_seen) begin
               state_n = S_PHASE;
            end else if (expired) begin
               state_n = S_IDLE;
               fin_bad = 1'b1;
            end
         end
         S_PHASE:    state_n = S_ENABLE;
         S_ENABLE:   state_n = S_WAIT_ON;
         S_WAIT_ON: begin
            if (ckout_seen) begin
               state_n = S_LOCKIN;
            end else if (expired) begin
               state_n = S_IDLE;
               fin_bad = 1'b1;
            end
         end
         S_LOCKIN: begin
            state_n = S_IDLE;
            fin_ok  = 1'b1;
         end
         default:    state_n = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         phase_q    <= '0;
         done       <= 1'b0;
         err        <= 1'b0;
         fail_phase <= '0;
      end else begin
         state <= state_n;
         done  <= fin_ok;
         err   <= fin_bad;
         if ((state == S_IDLE) && start) begin
            phase_q <= phase_req;
         end
         if (fin_bad) begin
            fail_phase <= phase_q;
         end
      end
   end

   assign busy      = (state != S_IDLE);
   assign cfg_wr_en = (state == S_QUIESCE) || (state == S_PHASE) ||
                      (state == S_ENABLE)  || (state == S_LOCKIN);

endmodule

// File: rtl/dps_checker.sv
module dps_checker (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic wr_en,
   input logic dll_en_w,
   input logic cdr_en_w,
   input logic ckout_w,
   input logic cdr_ext_w,
   input logic done,
   input logic err
);

   AST_QUIESCE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> wr_en && !cdr_en_w && !ckout_w && cdr_ext_w && dll_en_w); // R2

   AST_WRITE_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy); // R3

   AST_LOCKIN_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(wr_en) && $past(cdr_en_w) && !$past(cdr_ext_w)); // R7

   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err); // R9

   AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |-> !busy && !wr_en && !(done && err)); // R9

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10

endmodule

bind dll_phase_seq dps_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .wr_en     (cfg_wr_en),
   .dll_en_w  (cfg_wr_data[DLL_EN_BIT]),
   .cdr_en_w  (cfg_wr_data[CDR_EN_BIT]),
   .ckout_w   (cfg_wr_data[CKOUT_BIT]),
   .cdr_ext_w (cfg_wr_data[CDR_EXT_BIT]),
   .done      (done),
   .err       (err)
);

// File: tb/dll_phase_seq_test.sv
`timescale 1ns/1ps
module dll_phase_seq_test;

   localparam int DIV   = 4;
   localparam int LIM   = 5;
   localparam int TLAST = LIM * DIV - 1;
   localparam logic [31:0] INIT = 32'hA5C4_3E5A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  phase_req = '0;
   logic [31:0] cfg_rd;
   logic        cfg_wr_en;
   logic [31:0] cfg_wr_data;
   logic        busy, done, err;
   logic [3:0]  fail_phase;

   always #2 clk = ~clk;

   dll_phase_seq #(.TICK_DIV(DIV), .POLL_LIMIT(LIM)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .phase_req(phase_req),
      .cfg_rd(cfg_rd), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
      .busy(busy), .done(done), .err(err), .fail_phase(fail_phase)
   );

   // register model: bit 18 readback follows written value after rb_delay edges
   logic [31:0] cfg;
   logic [63:0] hist;
   int          rb_delay = 0;
   logic        rb;
   assign rb     = hist[rb_delay];
   assign cfg_rd = {cfg[31:19], rb, cfg[17:0]};

   always @(posedge clk) begin
      logic [31:0] nx;
      if (!rst_n) begin
         cfg  <= INIT;
         hist <= '1;
      end else begin
         nx = cfg_wr_en ? cfg_wr_data : cfg;
         cfg  <= nx;
         hist <= {hist[62:0], nx[18]};
      end
   end

   int unsigned gray_ref [16] = '{0, 1, 3, 2, 6, 7, 5, 4, 12, 13, 15, 14, 10, 11, 9, 8};

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [3:0] exp_phase = '0;
   logic [35:0] exp_q[$];
   string       tag_q[$];

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic push(input bit b, input bit w, input logic [31:0] d,
                       input bit dn, input bit er, input string tag);
      exp_q.push_back({b, w, d, dn, er});
      tag_q.push_back(tag);
   endtask

   // cycle-by-cycle reference comparison
   always @(negedge clk) begin
      logic [35:0] e;
      string t;
      if (rst_n) begin
         cyc++;
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
         end else begin
            e = '0;
            t = "R10";
         end
         chk(t, "busy",  32'(busy),      32'(e[35]));
         chk(t, "wr_en", 32'(cfg_wr_en), 32'(e[34]));
         chk(t, "done",  32'(done),      32'(e[1]));
         chk(t, "err",   32'(err),       32'(e[0]));
         if (e[34]) chk(t, "wr_data", cfg_wr_data, e[33:2]);
         if (e[0])  chk("R9", "fail_phase", 32'(fail_phase), 32'(exp_phase));
         if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   task automatic run_seq(input logic [3:0] p, input int d, input bit poke);
      int m0, m1;
      logic [31:0] rd0, v1, v2, v3, v4;
      logic [3:0] field_before;
      bit ok;
      @(posedge clk); #1;
      rb_delay  = d;
      start     = 1'b1;
      phase_req = p;
      @(posedge clk); #1;
      start     = 1'b0;
      exp_phase = p;
      field_before = cfg[23:20];
      m0  = (rb == 1'b0) ? 0 : d;
      m1  = d;
      ok  = 1'b0;
      rd0 = cfg_rd;
      v1 = (rd0 & ~32'h0006_0000) | 32'h0009_0000;
      push(1, 1, v1, 0, 0, "R2");
      if (m0 > TLAST) begin
         for (int i = 0; i <= TLAST; i++) push(1, 0, '0, 0, 0, "R8");
         push(0, 0, '0, 0, 1, "R9");
      end else begin
         for (int i = 0; i <= m0; i++) push(1, 0, '0, 0, 0, "R3");
         v2 = (v1 & ~32'h00F0_0000) | (32'(gray_ref[p]) << 20);
         push(1, 1, v2, 0, 0, "R4");
         v3 = v2 | 32'h0004_0000;
         push(1, 1, v3, 0, 0, "R5");
         if (m1 > TLAST) begin
            for (int i = 0; i <= TLAST; i++) push(1, 0, '0, 0, 0, "R8");
            push(0, 0, '0, 0, 1, "R9");
         end else begin
            for (int i = 0; i <= m1; i++) push(1, 0, '0, 0, 0, "R6");
            v4 = (v3 | 32'h0002_0000) & ~32'h0008_0000;
            push(1, 1, v4, 0, 0, "R7");
            push(0, 0, '0, 1, 0, "R10");
            ok = 1'b1;
         end
      end
      if (poke) begin
         repeat (4) @(posedge clk);
         #1 start = 1'b1; phase_req = 4'h9;
         @(posedge clk);
         #1 start = 1'b0;
      end
      while (exp_q.size() != 0) @(negedge clk);
      repeat (25) @(posedge clk);
      if (ok) begin
         chk(poke ? "R11" : "R4", "phase field", 32'(cfg[23:20]), gray_ref[p]);
         chk("R7", "ctrl bits 19..16", 32'(cfg[19:16]), 32'h7);
         chk("R7", "upper bits", 32'(cfg[31:24]), 32'(INIT[31:24]));
         chk("R2", "lower bits", 32'(cfg[15:0]), 32'(INIT[15:0]));
      end else if (m0 > TLAST) begin
         chk("R9", "phase field untouched", 32'(cfg[23:20]), 32'(field_before));
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "busy in reset",  32'(busy),      0);
      chk("R1", "wr_en in reset", 32'(cfg_wr_en), 0);
      chk("R1", "done in reset",  32'(done),      0);
      chk("R1", "err in reset",   32'(err),       0);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (5) @(posedge clk);

      run_seq(4'h5, 0, 0);          // R3 immediate readback
      run_seq(4'hF, 3, 0);          // R6 delayed readback
      run_seq(4'h0, 10, 1);         // R11 start ignored mid-poll
      run_seq(4'h8, TLAST, 0);      // R8 match on last tick
      run_seq(4'hC, TLAST + 1, 0);  // R8 timeout in first poll
      run_seq(4'h6, TLAST + 1, 0);  // R9 timeout in second poll
      run_seq(4'hA, 2, 0);          // recovery after error
      for (int i = 0; i < 16; i++) run_seq(4'(i), 1, 0);  // R4 all codes

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule